// File: doc/BRIEF.md
# USB transceiver and link controller reset sequencer

This block brings a USB 2.0 transceiver and its link controller out of power-on reset in the right order. A power-good or global reset input (active low, asynchronous) puts both resets into the asserted state together. Once the system clock has counted out a minimum hold of at least 10 microseconds, the transceiver reset is released. The controller reset stays asserted until the transceiver's output clock has been seen running. Its release then passes through a short reset synchronizer clocked by that transceiver clock. A fixed delay on its own never releases the controller.

Clock presence is judged in the system clock domain. A flag that toggles on every transceiver clock edge is synchronized, and its transitions are counted inside a repeating window. If no clock shows up within a timeout after the transceiver is released, the block parks in an error state and keeps the controller in reset until the global reset is applied again. A separate strap output powers down the transceiver's dual-role circuitry whenever the system runs as a fixed-role host or device.

Top module: `usb_rst_seq`

## Requirements
- R1: While `rst_n` is low, `phy_rst` = 1, `ctrl_rst` = 1, `clk_err` = 0 and `seq_state` = 2'b00. This holds whether or not `phy_clk` is toggling.
- R2: After `rst_n` rises, `phy_rst` stays 1 for HOLD_CYC + 1 rising edges of `clk_sys`. HOLD_CYC = ceil(SYS_CLK_HZ × HOLD_NS / 1e9), and HOLD_NS defaults to 10000. At 50 MHz the release therefore comes between 10.0 µs and 10.05 µs after reset release.
- R3: `ctrl_rst` is never 0 while `phy_rst` is 1. The transceiver is always released first.
- R4: `ctrl_rst` falls only after the clock has been detected. Detection needs EDGE_MIN (default 8) transitions of the synchronized toggle flag inside one WINDOW_CYC (default 64) cycle window. The release then passes through SYNC_STAGES (default 2) flops clocked by `phy_clk`.
- R5: A transceiver clock too slow to give EDGE_MIN flag transitions in one window is never treated as present. It ends in the error state.
- R6: If the clock is not detected within TIMEOUT_CYC (default 2000) `clk_sys` cycles after `phy_rst` falls, the block sets `clk_err` = 1 and `seq_state` = 2'b11, and holds `ctrl_rst` at 1. This error is sticky until `rst_n` goes low, even if the clock starts later.
- R7: `role_strap_off` = 1 when `dual_role` = 0 (fixed role), and 0 when `dual_role` = 1.
- R8: Driving `rst_n` low at any time sets `phy_rst` and `ctrl_rst` to 1 and clears `clk_err` at once, without a clock edge. The full sequence then runs again after release.
- R9: `seq_state` encodes the sequencer state as 2'b00 for both held, 2'b01 for transceiver released and waiting for the clock, 2'b10 for running, and 2'b11 for error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous power-good / global reset, active low |
| phy_clk | input | 1 | Output clock of the transceiver |
| dual_role | input | 1 | 1 selects dual-role operation, 0 selects fixed-role |
| phy_rst | output | 1 | Transceiver power-on reset, active high |
| ctrl_rst | output | 1 | Link controller reset, active high, released on `phy_clk` |
| role_strap_off | output | 1 | 1 powers down the transceiver's dual-role circuitry |
| seq_state | output | 2 | Sequencer state (encoding in R9) |
| clk_err | output | 1 | Sticky flag: transceiver clock not detected in time |

## Verification
The bench times the transceiver release against the 10 µs floor. A counter that is off by one or that starts late would release just under the limit or well past the allowed slack. It runs the sequence with the transceiver clock absent and with it far too slow. A detector that counted a single edge, or that released on a fixed delay, would free the controller in those runs instead of raising the error. It also starts the clock after the error is raised, to catch an error flag that is not sticky. It pulls `rst_n` low in the middle of a clock cycle while the block is running. This exposes outputs that wait for a clock edge before asserting, and an error flag that survives the reset.

// File: rtl/usb_rst_seq_pkg.sv
package usb_rst_seq_pkg;

    typedef enum logic [1:0] {
        ST_HOLD = 2'b00,
        ST_WAIT = 2'b01,
        ST_RUN  = 2'b10,
        ST_ERR  = 2'b11
    } seq_st_e;

    // Cycles needed so that hold_ns is never undershot (ceiling division).
    function automatic longint hold_cycles(longint clk_hz, longint hold_ns);
        return (clk_hz * hold_ns + 64'd999_999_999) / 64'd1_000_000_000;
    endfunction

endpackage

// File: rtl/usb_rst_clkdet.sv
module usb_rst_clkdet #(
    parameter int EDGE_MIN   = 8,
    parameter int WINDOW_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic phy_clk,
    input  logic phy_rst,
    input  logic en,
    output logic present
);
    localparam int EW = $clog2(EDGE_MIN + 1);
    localparam int WW = (WINDOW_CYC > 1) ? $clog2(WINDOW_CYC) : 1;

    typedef struct packed {
        logic [WW-1:0] win;
        logic [EW-1:0] edges;
        logic          seen;
    } det_t;

    det_t       q, d;
    logic       tog_q;
    logic [2:0] sync_q;
    logic       flag_edge;
    logic       wrap;

    // Toggle flag in the transceiver clock domain.
    always_ff @(posedge phy_clk or posedge phy_rst) begin
        if (phy_rst) tog_q <= 1'b0;
        else         tog_q <= ~tog_q;
    end

    // Bring the flag into the system domain; last stage only feeds edge detect.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], tog_q};
    end

    assign flag_edge = sync_q[2] ^ sync_q[1];
    assign wrap      = (q.win == WW'(WINDOW_CYC - 1));

    always_comb begin
        d = q;
        if (!en) begin
            d = '0;
        end else if (!q.seen) begin
            d.win = wrap ? '0 : q.win + 1'b1;
            if (flag_edge && (q.edges == EW'(EDGE_MIN - 1))) begin
                d.seen = 1'b1;
            end
            if (wrap) d.edges = {{(EW-1){1'b0}}, flag_edge};
            else      d.edges = q.edges + {{(EW-1){1'b0}}, flag_edge};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign present = q.seen;

endmodule

// File: rtl/usb_rst_relsync.sv
module usb_rst_relsync #(
    parameter int STAGES = 2
) (
    input  logic dst_clk,
    input  logic hold_in,
    output logic rst_out
);
    logic [STAGES-1:0] stg_q;

    // Assert at once, release only after STAGES destination clock edges.
    always_ff @(posedge dst_clk or posedge hold_in) begin
        if (hold_in) stg_q <= '1;
        else         stg_q <= {stg_q[STAGES-2:0], 1'b0};
    end

    assign rst_out = stg_q[STAGES-1];

endmodule

// File: rtl/usb_rst_seq.sv
module usb_rst_seq #(
    parameter longint SYS_CLK_HZ  = 50_000_000,
    parameter int     HOLD_NS     = 10_000,
    parameter int     EDGE_MIN    = 8,
    parameter int     WINDOW_CYC  = 64,
    parameter int     TIMEOUT_CYC = 2000,
    parameter int     SYNC_STAGES = 2
) (
    input  logic       clk_sys,
    input  logic       rst_n,
    input  logic       phy_clk,
    input  logic       dual_role,
    output logic       phy_rst,
    output logic       ctrl_rst,
    output logic       role_strap_off,
    output logic [1:0] seq_state,
    output logic       clk_err
);
    import usb_rst_seq_pkg::*;

    localparam int HOLD_CYC = int'(hold_cycles(SYS_CLK_HZ, longint'(HOLD_NS)));
    localparam int CNT_MAX  = (HOLD_CYC > TIMEOUT_CYC) ? HOLD_CYC : TIMEOUT_CYC;
    localparam int CW       = $clog2(CNT_MAX + 1);

    typedef struct packed {
        seq_st_e       st;
        logic [CW-1:0] cnt;
        logic          phy_hold;
        logic          ctrl_hold;
        logic          err;
    } seq_t;

    seq_t q, d;
    logic clk_seen;

    usb_rst_clkdet #(
        .EDGE_MIN  (EDGE_MIN),
        .WINDOW_CYC(WINDOW_CYC)
    ) u_det (
        .clk    (clk_sys),
        .rst_n  (rst_n),
        .phy_clk(phy_clk),
        .phy_rst(q.phy_hold),
        .en     (q.st == ST_WAIT),
        .present(clk_seen)
    );

    usb_rst_relsync #(
        .STAGES(SYNC_STAGES)
    ) u_rel (
        .dst_clk(phy_clk),
        .hold_in(q.ctrl_hold),
        .rst_out(ctrl_rst)
    );

    always_comb begin
        d = q;
        case (q.st)
            ST_HOLD: begin
                if (q.cnt == CW'(HOLD_CYC)) begin
                    d.st       = ST_WAIT;
                    d.cnt      = '0;
                    d.phy_hold = 1'b0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_WAIT: begin
                if (clk_seen) begin
                    d.st        = ST_RUN;
                    d.ctrl_hold = 1'b0;
                end else if (q.cnt == CW'(TIMEOUT_CYC - 1)) begin
                    d.st  = ST_ERR;
                    d.err = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_RUN, ST_ERR: ;
            default: d = q;
        endcase
    end

    always_ff @(posedge clk_sys or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_HOLD, cnt: '0, phy_hold: 1'b1, ctrl_hold: 1'b1, err: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign phy_rst        = q.phy_hold;
    assign seq_state      = q.st;
    assign clk_err        = q.err;
    assign role_strap_off = ~dual_role;

endmodule

// File: rtl/usb_rst_seq_chk.sv
module usb_rst_seq_chk #(
    parameter longint SYS_CLK_HZ = 50_000_000,
    parameter int     HOLD_NS    = 10_000
) (
    input logic       clk_sys,
    input logic       rst_n,
    input logic       phy_rst,
    input logic       ctrl_rst,
    input logic       clk_err,
    input logic [1:0] seq_state
);
    localparam int HOLD_CYC =
        int'(usb_rst_seq_pkg::hold_cycles(SYS_CLK_HZ, longint'(HOLD_NS)));

    logic [31:0] held_cnt;

    always_ff @(posedge clk_sys or negedge rst_n) begin
        if (!rst_n)       held_cnt <= '0;
        else if (phy_rst) held_cnt <= held_cnt + 1'b1;
    end

    AST_HOLD_MIN: assert property (@(posedge clk_sys) disable iff (!rst_n)
        $fell(phy_rst) |-> (held_cnt >= 32'(HOLD_CYC)));                   // R2
    AST_CTRL_AFTER_PHY: assert property (@(posedge clk_sys) disable iff (!rst_n)
        !ctrl_rst |-> !phy_rst);                                            // R3
    AST_RUN_PHY_FREE: assert property (@(posedge clk_sys) disable iff (!rst_n)
        (seq_state == 2'b10) |-> !phy_rst);                                 // R9
    AST_CTRL_FREE_IN_RUN: assert property (@(posedge clk_sys) disable iff (!rst_n)
        $fell(ctrl_rst) |-> (seq_state == 2'b10));                          // R4
    AST_ERR_FROM_WAIT: assert property (@(posedge clk_sys) disable iff (!rst_n)
        $rose(clk_err) |-> ($past(seq_state) == 2'b01));                    // R6
    AST_ERR_STICKY: assert property (@(posedge clk_sys) disable iff (!rst_n)
        clk_err |=> clk_err);                                               // R6
    AST_ERR_KEEPS_CTRL: assert property (@(posedge clk_sys) disable iff (!rst_n)
        clk_err |-> ctrl_rst);                                              // R6

endmodule

bind usb_rst_seq usb_rst_seq_chk #(
    .SYS_CLK_HZ(SYS_CLK_HZ),
    .HOLD_NS   (HOLD_NS)
) u_chk (
    .clk_sys  (clk_sys),
    .rst_n    (rst_n),
    .phy_rst  (phy_rst),
    .ctrl_rst (ctrl_rst),
    .clk_err  (clk_err),
    .seq_state(seq_state)
);

// File: tb/usb_rst_seq_test.sv
`timescale 1ns/1ps
module usb_rst_seq_test;
    localparam int TIMEOUT  = 2000;
    localparam int EDGE_MIN = 8;

    logic       clk_sys = 1'b0;
    logic       rst_n   = 1'b0;
    logic       phy_clk = 1'b0;
    logic       dual_role = 1'b1;
    logic       phy_rst, ctrl_rst, role_strap_off, clk_err;
    logic [1:0] seq_state;

    int     phy_half = 18;
    logic   phy_en   = 1'b1;
    longint cyc      = 0;
    int     nchk     = 0;
    int     nfail    = 0;

    // Scoreboard item: which output, expected value, cycle it is due.
    typedef struct {
        string  req;
        int     sig;
        int     exp;
        longint due;
    } sb_item_t;
    sb_item_t sbq[$];
    sb_item_t cur;

    usb_rst_seq #(
        .SYS_CLK_HZ (50_000_000),
        .HOLD_NS    (10_000),
        .EDGE_MIN   (EDGE_MIN),
        .WINDOW_CYC (64),
        .TIMEOUT_CYC(TIMEOUT),
        .SYNC_STAGES(2)
    ) uut (
        .clk_sys       (clk_sys),
        .rst_n         (rst_n),
        .phy_clk       (phy_clk),
        .dual_role     (dual_role),
        .phy_rst       (phy_rst),
        .ctrl_rst      (ctrl_rst),
        .role_strap_off(role_strap_off),
        .seq_state     (seq_state),
        .clk_err       (clk_err)
    );

    always #10 clk_sys = ~clk_sys;
    always #(phy_half) if (phy_en) phy_clk = ~phy_clk;
    always @(posedge clk_sys) cyc <= cyc + 1;

    task automatic check(string req, string what, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int pick(int sig);
        case (sig)
            0: return int'(phy_rst);
            1: return int'(ctrl_rst);
            2: return int'(role_strap_off);
            3: return int'(seq_state);
            default: return int'(clk_err);
        endcase
    endfunction

    function automatic string sig_name(int sig);
        case (sig)
            0: return "phy_rst";
            1: return "ctrl_rst";
            2: return "role_strap_off";
            3: return "seq_state";
            default: return "clk_err";
        endcase
    endfunction

    task automatic expect_at(string req, int sig, int exp, int delay);
        sb_item_t it;
        it.req = req; it.sig = sig; it.exp = exp; it.due = cyc + delay;
        sbq.push_back(it);
    endtask

    task automatic drain();
        wait (sbq.size() == 0);
    endtask

    // Monitor: compare due items away from the active edge.
    always @(negedge clk_sys) begin
        while (sbq.size() > 0 && sbq[0].due <= cyc) begin
            cur = sbq.pop_front();
            check(cur.req, sig_name(cur.sig), pick(cur.sig), cur.exp);
        end
    end

    task automatic release_rst(output realtime t_rel);
        @(negedge clk_sys);
        rst_n = 1'b1;
        t_rel = $realtime;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    endtask

    initial begin
        repeat (200000) @(posedge clk_sys);
        nfail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        realtime t_rel, t_phy, t_ctrl;
        bit      fell;

        // R1 reset state with the transceiver clock running
        #95;
        check("R1", "phy_rst", int'(phy_rst), 1);
        check("R1", "ctrl_rst", int'(ctrl_rst), 1);
        check("R1", "clk_err", int'(clk_err), 0);
        check("R9", "seq_state hold", int'(seq_state), 0);
        check("R7", "strap dual", int'(role_strap_off), 0);

        // Normal bring-up
        release_rst(t_rel);
        @(negedge phy_rst);
        t_phy = $realtime;
        check("R2", "hold too short", (t_phy - t_rel) >= 10000.0 ? 1 : 0, 1);
        check("R2", "hold too long", (t_phy - t_rel) <= 10050.0 ? 1 : 0, 1);
        @(negedge clk_sys);
        expect_at("R9", 3, 1, 0);
        expect_at("R3", 1, 1, 0);
        drain();
        fell = 0;
        fork
            begin wait (!ctrl_rst); fell = 1; end
            repeat (300) @(posedge clk_sys);
        join_any
        disable fork;
        t_ctrl = $realtime;
        check("R4", "ctrl_rst released", int'(fell), 1);
        check("R4", "release too early", (t_ctrl - t_phy) >= (EDGE_MIN - 1) * 36.0 ? 1 : 0, 1);
        @(negedge clk_sys);
        expect_at("R9", 3, 2, 1);
        expect_at("R4", 4, 0, 1);
        drain();
        dual_role = 1'b0;
        expect_at("R7", 2, 1, 1);
        drain();
        dual_role = 1'b1;
        expect_at("R7", 2, 0, 1);
        drain();

        // R8 reassert in the middle of a cycle while running
        @(posedge clk_sys);
        #7 rst_n = 1'b0;
        #1;
        check("R8", "phy_rst async", int'(phy_rst), 1);
        check("R8", "ctrl_rst async", int'(ctrl_rst), 1);
        check("R8", "seq_state async", int'(seq_state), 0);
        #100;
        release_rst(t_rel);
        @(negedge phy_rst);
        t_phy = $realtime;
        check("R8", "restart hold", (t_phy - t_rel) >= 10000.0 ? 1 : 0, 1);
        @(negedge clk_sys);
        expect_at("R8", 1, 0, 200);
        expect_at("R8", 3, 2, 200);
        drain();

        // R6 transceiver clock absent
        rst_n = 1'b0;
        phy_en = 1'b0;
        #100;
        release_rst(t_rel);
        @(negedge phy_rst);
        @(negedge clk_sys);
        expect_at("R6", 3, 1, TIMEOUT - 20);
        expect_at("R6", 4, 0, TIMEOUT - 20);
        expect_at("R6", 1, 1, TIMEOUT - 20);
        expect_at("R6", 4, 1, TIMEOUT + 10);
        expect_at("R6", 3, 3, TIMEOUT + 10);
        expect_at("R6", 1, 1, TIMEOUT + 10);
        drain();
        phy_en = 1'b1;
        expect_at("R6", 4, 1, 300);
        expect_at("R6", 1, 1, 300);
        drain();
        rst_n = 1'b0;
        #1;
        check("R8", "clk_err cleared", int'(clk_err), 0);
        #100;

        // R5 clock far too slow to meet the edge count in a window
        phy_half = 2000;
        release_rst(t_rel);
        @(negedge phy_rst);
        @(negedge clk_sys);
        expect_at("R5", 1, 1, TIMEOUT - 5);
        expect_at("R5", 4, 1, TIMEOUT + 10);
        expect_at("R5", 3, 3, TIMEOUT + 10);
        drain();

        summary();
        $finish;
    end

endmodule